// File: doc/BRIEF.md
# Flash Block Access Protection Checker

This block sits between an access source and a 64 KB flash array and screens every access against two per-block rights bits. The array is split into 2 KB blocks. Each block owns a program/erase enable bit and a read enable bit, and the access address selects which pair applies. Instruction fetches always pass. Data reads pass only when the read bit is set, and a blocked data read returns all-zero data rather than an error. Program and erase operations pass only when the program/erase bit is set. A blocked program or erase never reaches the array's strobes.

All screening is combinational, so a permitted access sees the same cycle timing it would have without the block. A refused access sets a sticky violation flag. Software clears that flag by writing 1 to it. The interrupt line is the flag gated by a software-written mask bit.

The access side is a plain qualified strobe (`acc_valid`) with no ready signal. The block never applies back-pressure, because it only gates and never stores an access. The source owns any flow control toward the array.

Top module: `flash_guard`

## Requirements
- R1: The block index is address bits [15:11]. Bit n of `pe_en` and bit n of `rd_en` govern block n. No other address bit affects the result.
- R2: An instruction fetch (`acc_kind` = 1) with `acc_valid` high is always permitted, and `rd_data` equals `flash_rdata` in the same cycle.
- R3: A program (`acc_kind` = 2) or an erase (`acc_kind` = 3) to a block whose program/erase bit is 0 is refused: `acc_permit` is low and both `prog_stb` and `erase_stb` are low.
- R4: A program or an erase to a block whose program/erase bit is 1 is permitted. It raises only the strobe of its own kind, in the same cycle, and `rd_data` is zero.
- R5: A data read (`acc_kind` = 0) to a block whose read bit is 0 is refused, and `rd_data` is all zeros.
- R6: A data read to a block whose read bit is 1 is permitted, and `rd_data` equals `flash_rdata` in the same cycle.
- R7: While `acc_valid` is low, `acc_permit`, `prog_stb` and `erase_stb` are low and `rd_data` is zero.
- R8: A refused access sets `irq_status` at the next clock edge. The flag then stays set until it is cleared.
- R9: A cycle with `stat_clr` high clears `irq_status` at the next edge. If a refused access occurs in that same cycle, the flag is set instead.
- R10: A cycle with `mask_wr` high loads `mask_wdata` into `irq_mask` at the next edge. `irq` always equals `irq_status` AND `irq_mask`.
- R11: After reset, `irq_status`, `irq_mask` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 16 | Byte address of the access |
| acc_kind | input | 2 | 0 data read, 1 fetch, 2 program, 3 erase |
| flash_rdata | input | 32 | Raw data from the array |
| pe_en | input | 32 | Program/erase enable, one bit per block |
| rd_en | input | 32 | Read enable, one bit per block |
| stat_clr | input | 1 | Write-1-to-clear of the violation flag |
| mask_wr | input | 1 | Load strobe for the interrupt mask |
| mask_wdata | input | 1 | Value for the interrupt mask |
| acc_permit | output | 1 | Access allowed |
| prog_stb | output | 1 | Gated program strobe to the array |
| erase_stb | output | 1 | Gated erase strobe to the array |
| rd_data | output | 32 | Filtered read data |
| irq_status | output | 1 | Sticky violation flag |
| irq_mask | output | 1 | Interrupt mask bit |
| irq | output | 1 | Masked violation interrupt |

## Verification
The clear of the violation flag and a fresh violation can fall in the same cycle. Two kinds of cycle provoke this overlap. The first is a directed cycle that drives `stat_clr` together with a program to a locked block. The second is a random sweep in which clears, mask writes and refused accesses coincide freely. In the overlap cycle, the flag must read set one edge later. A behavioural model in the bench judges every cycle, and with it the gated `irq`.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_FETCH = 2'd1,
    ACC_PROG  = 2'd2,
    ACC_ERASE = 2'd3
  } acc_kind_t;

  typedef struct packed {
    logic pe;
    logic rd;
  } blk_rights_t;
endpackage

// File: rtl/fg_decode.sv
module fg_decode #(
  parameter int IDX_W   = 5,
  parameter int NUM_BLK = 32
) (
  input  logic [IDX_W-1:0]            blk_idx,
  input  logic [NUM_BLK-1:0]          pe_en,
  input  logic [NUM_BLK-1:0]          rd_en,
  output flash_guard_pkg::blk_rights_t rights
);
  import flash_guard_pkg::*;

  blk_rights_t table_q [NUM_BLK];

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    assign table_q[b].pe = pe_en[b];
    assign table_q[b].rd = rd_en[b];
  end

  assign rights = table_q[blk_idx];
endmodule

// File: rtl/fg_policy.sv
module fg_policy (
  input  logic                         acc_valid,
  input  flash_guard_pkg::acc_kind_t   kind,
  input  flash_guard_pkg::blk_rights_t rights,
  output logic                         permit,
  output logic                         prog_stb,
  output logic                         erase_stb,
  output logic                         pass_data,
  output logic                         violation
);
  import flash_guard_pkg::*;

  logic allow;

  always_comb begin
    unique case (kind)
      ACC_READ:  allow = rights.rd;
      ACC_FETCH: allow = 1'b1;
      ACC_PROG:  allow = rights.pe;
      default:   allow = rights.pe;
    endcase
  end

  assign permit    = acc_valid & allow;
  assign violation = acc_valid & ~allow;
  assign prog_stb  = permit & (kind == ACC_PROG);
  assign erase_stb = permit & (kind == ACC_ERASE);
  assign pass_data = permit & ((kind == ACC_READ) | (kind == ACC_FETCH));
endmodule

// File: rtl/fg_rfilter.sv
module fg_rfilter #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              pass,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign dout[l*LANE_W +: LANE_W] = din[l*LANE_W +: LANE_W] & {LANE_W{pass}};
  end
endmodule

// File: rtl/fg_irq.sv
module fg_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic violation,
  input  logic stat_clr,
  input  logic mask_wr,
  input  logic mask_wdata,
  output logic status,
  output logic mask,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= 1'b0;
      mask   <= 1'b0;
    end else begin
      if (violation)     status <= 1'b1;
      else if (stat_clr) status <= 1'b0;
      if (mask_wr)       mask   <= mask_wdata;
    end
  end

  assign irq = status & mask;
endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int ADDR_W   = 16,
  parameter int BLK_BITS = 11,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = ADDR_W - BLK_BITS,
  localparam int NUM_BLK = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [1:0]         acc_kind,
  input  logic [DATA_W-1:0]  flash_rdata,
  input  logic [NUM_BLK-1:0] pe_en,
  input  logic [NUM_BLK-1:0] rd_en,
  input  logic               stat_clr,
  input  logic               mask_wr,
  input  logic               mask_wdata,
  output logic               acc_permit,
  output logic               prog_stb,
  output logic               erase_stb,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq_status,
  output logic               irq_mask,
  output logic               irq
);
  import flash_guard_pkg::*;

  blk_rights_t rights;
  acc_kind_t   kind;
  logic        pass_data;
  logic        violation;
  logic        unused_lo;

  assign kind      = acc_kind_t'(acc_kind);
  assign unused_lo = ^acc_addr[BLK_BITS-1:0];

  fg_decode #(.IDX_W(IDX_W), .NUM_BLK(NUM_BLK)) u_dec (
    .blk_idx (acc_addr[ADDR_W-1:BLK_BITS]),
    .pe_en   (pe_en),
    .rd_en   (rd_en),
    .rights  (rights)
  );

  fg_policy u_pol (
    .acc_valid (acc_valid),
    .kind      (kind),
    .rights    (rights),
    .permit    (acc_permit),
    .prog_stb  (prog_stb),
    .erase_stb (erase_stb),
    .pass_data (pass_data),
    .violation (violation)
  );

  fg_rfilter #(.DATA_W(DATA_W)) u_flt (
    .pass (pass_data),
    .din  (flash_rdata),
    .dout (rd_data)
  );

  fg_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .violation  (violation),
    .stat_clr   (stat_clr),
    .mask_wr    (mask_wr),
    .mask_wdata (mask_wdata),
    .status     (irq_status),
    .mask       (irq_mask),
    .irq        (irq)
  );
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
  parameter int ADDR_W   = 16,
  parameter int BLK_BITS = 11,
  parameter int DATA_W   = 32,
  parameter int NUM_BLK  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic [ADDR_W-1:0]  acc_addr,
  input logic [1:0]         acc_kind,
  input logic [DATA_W-1:0]  flash_rdata,
  input logic [NUM_BLK-1:0] pe_en,
  input logic [NUM_BLK-1:0] rd_en,
  input logic               stat_clr,
  input logic               acc_permit,
  input logic               prog_stb,
  input logic               erase_stb,
  input logic [DATA_W-1:0]  rd_data,
  input logic               irq_status,
  input logic               irq_mask,
  input logic               irq
);
  logic [ADDR_W-BLK_BITS-1:0] idx;
  logic                       refused;
  assign idx     = acc_addr[ADDR_W-1:BLK_BITS];
  assign refused = acc_valid & ~acc_permit;

  p_fetch_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'd1) |-> (acc_permit && rd_data == flash_rdata));

  p_strobe_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_stb || erase_stb) |-> pe_en[idx]);

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_stb, erase_stb}));

  p_zero_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'd0 && !rd_en[idx]) |-> (rd_data == '0));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!acc_permit && !prog_stb && !erase_stb && rd_data == '0));

  p_sticky_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> irq_status);

  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status && !stat_clr) |=> irq_status);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !refused) |=> !irq_status);

  p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_status && irq_mask));
endmodule

bind flash_guard fg_checker #(
  .ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS), .DATA_W(DATA_W), .NUM_BLK(NUM_BLK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_kind(acc_kind), .flash_rdata(flash_rdata), .pe_en(pe_en), .rd_en(rd_en),
  .stat_clr(stat_clr), .acc_permit(acc_permit), .prog_stb(prog_stb),
  .erase_stb(erase_stb), .rd_data(rd_data), .irq_status(irq_status),
  .irq_mask(irq_mask), .irq(irq)
);

// File: tb/sim_flash_guard.sv
`timescale 1ns/1ps
module sim_flash_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic [15:0] acc_addr;
  logic [1:0]  acc_kind;
  logic [31:0] flash_rdata;
  logic [31:0] pe_en;
  logic [31:0] rd_en;
  logic        stat_clr;
  logic        mask_wr;
  logic        mask_wdata;
  logic        acc_permit;
  logic        prog_stb;
  logic        erase_stb;
  logic [31:0] rd_data;
  logic        irq_status;
  logic        irq_mask;
  logic        irq;

  int tests = 0;
  int fails = 0;
  int m_status = 0;
  int m_mask = 0;

  always #10 clk = ~clk;

  flash_guard u0 (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, judge before the rising edge,
  // then advance the model at the rising edge.
  task automatic cycle(input bit v, input int blk, input int lo, input int k,
                       input bit clr, input bit mw, input bit md);
    int          e_permit, e_prog, e_erase, refused, rdbit, pebit;
    logic [31:0] e_data;
    string       tag;
    @(negedge clk);
    acc_valid   = v;
    acc_addr    = 16'((blk << 11) | (lo & 16'h07ff));
    acc_kind    = 2'(k);
    flash_rdata = $urandom;
    stat_clr    = clr;
    mask_wr     = mw;
    mask_wdata  = md;
    rdbit = int'(rd_en[blk]);
    pebit = int'(pe_en[blk]);
    e_permit = 0;
    if (v) begin
      if (k == 1) e_permit = 1;
      else if (k == 0) e_permit = rdbit;
      else e_permit = pebit;
    end
    e_prog  = (e_permit == 1 && k == 2) ? 1 : 0;
    e_erase = (e_permit == 1 && k == 3) ? 1 : 0;
    e_data  = (e_permit == 1 && k <= 1) ? flash_rdata : 32'h0;
    refused = (v && e_permit == 0) ? 1 : 0;
    if (!v) tag = "R7";
    else if (k == 1) tag = "R2";
    else if (k == 0) tag = (rdbit == 1) ? "R6" : "R5";
    else tag = (pebit == 1) ? "R4" : "R3";
    #5;
    chk(acc_permit == 1'(e_permit), {tag, "/R1 permit"}, acc_permit, e_permit);
    chk(prog_stb == 1'(e_prog), {tag, " prog_stb"}, prog_stb, e_prog);
    chk(erase_stb == 1'(e_erase), {tag, " erase_stb"}, erase_stb, e_erase);
    chk(rd_data == e_data, {tag, " rd_data"}, rd_data, e_data);
    chk(irq_status == 1'(m_status), "R8/R9 irq_status", irq_status, m_status);
    chk(irq_mask == 1'(m_mask), "R10 irq_mask", irq_mask, m_mask);
    chk(irq == 1'(m_status & m_mask), "R10 irq", irq, m_status & m_mask);
    @(posedge clk);
    if (refused == 1) m_status = 1;
    else if (clr) m_status = 0;
    if (mw) m_mask = int'(md);
  endtask

  initial begin
    #1000000;
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; acc_valid = 0; acc_addr = 0; acc_kind = 0; flash_rdata = 0;
    pe_en = 32'h0000_ffff; rd_en = 32'h00ff_00ff;
    stat_clr = 0; mask_wr = 0; mask_wdata = 0;
    repeat (3) @(posedge clk);
    #5;
    chk(irq_status == 0, "R11 status", irq_status, 0);
    chk(irq_mask == 0, "R11 mask", irq_mask, 0);
    chk(irq == 0, "R11 irq", irq, 0);
    @(negedge clk); rst_n = 1'b1;

    // idle, fetches from every kind of block (R2, R7)
    cycle(0, 3, 0, 2, 0, 0, 0);
    cycle(1, 31, 12, 1, 0, 0, 0);
    cycle(1, 0, 2047, 1, 0, 0, 0);
    // read-open and read-locked blocks (R5, R6), low address bits varied (R1)
    cycle(1, 2, 5, 0, 0, 0, 0);
    cycle(1, 8, 5, 0, 0, 0, 0);
    cycle(1, 23, 2047, 0, 0, 0, 0);
    // program/erase open then locked (R3, R4)
    cycle(1, 15, 0, 2, 0, 1, 1);
    cycle(1, 15, 0, 3, 0, 0, 0);
    cycle(1, 16, 100, 2, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 0);
    cycle(1, 17, 0, 3, 0, 0, 0);
    // clear without violation (R9), then clear with violation in same cycle
    cycle(0, 0, 0, 0, 1, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 0);
    cycle(1, 20, 0, 2, 1, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 1, 1, 0);
    cycle(0, 0, 0, 0, 0, 0, 0);

    // random sweep over rights, kinds, clears and mask writes
    for (int n = 0; n < 600; n++) begin
      if (n % 50 == 0) begin
        @(negedge clk);
        pe_en = $urandom; rd_en = $urandom;
      end
      cycle(($urandom % 4) != 0, int'($urandom % 32), int'($urandom % 2048),
            int'($urandom % 4), ($urandom % 5) == 0, ($urandom % 7) == 0,
            1'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule